// File: doc/BRIEF.md
# Prescaled Pulse Counter with Residue Recovery

This block measures the length of a long burst of input pulses that reach it only through an external divide-by-M prescaler. While acquisition is open, the block opens a gate so the external pulses reach the prescaler. It counts only the prescaler's overflow indications, and each overflow stands for M pulses. The low-order part of the count is still held inside the prescaler when the burst ends, and the block cannot read it directly.

To recover that leftover part, the block closes the gate, waits one settling cycle, and then feeds its own pulses into the prescaler at one pulse every two clocks until the prescaler overflows once more. If that takes k injected pulses, the prescaler held M − k counts, or zero when k equals M. The overflow count and the remainder are joined into a full-resolution total, and a one-cycle done strobe marks it as valid. The block assumes that the prescaler raises its overflow indication in the clock cycle after the pulse that wraps it. The prescaler is cleared only by wrapping, and the recovery sequence always ends with a wrap.

Top module: `prescaled_pulse_counter`

## Requirements
- R1: While reset is held and after it is released, gateEn, injPulse and done are low and total is zero.
- R2: gateEn is high from the cycle after a startReq is accepted in idle, up to and including the cycle in which stopReq is sampled high. gateEn is low at all other times.
- R3: Each rising edge of prescOvf seen during acquisition, or in the one settling cycle after it, adds exactly one to the overflow count. A level that stays high is counted once.
- R4: When done is high, total equals the number of external pulses that passed while gateEn was high, modulo 2^(COARSE_W+PRESC_W). The upper COARSE_W bits hold the overflow count and the lower PRESC_W bits hold the remainder.
- R5: After the settling cycle, injPulse is high every other cycle, starting two cycles after the stop cycle. It stops after the overflow rising edge that ends recovery, and it is never high together with gateEn.
- R6: An overflow caused by an external pulse in the stop cycle is counted as coarse and not taken as the end of recovery.
- R7: done is high for exactly one cycle, the cycle after the recovery overflow edge is sampled. total changes only in that cycle and holds its value until the next done.
- R8: A startReq that arrives while a measurement is in progress, including the done cycle, is ignored. It neither restarts nor clears the running count.
- R9: A stopReq sampled in idle has no effect. gateEn, injPulse and done stay low.
- R10: When the prescaler is empty at the end of the burst, exactly M pulses are injected and the remainder field of total is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to open a measurement; accepted only in idle |
| stopReq | input | 1 | Ends acquisition; sampled only while acquiring |
| prescOvf | input | 1 | Overflow indication from the external prescaler (edge-detected) |
| gateEn | output | 1 | Lets external pulses into the prescaler |
| injPulse | output | 1 | Block-generated pulse into the prescaler during recovery |
| done | output | 1 | One-cycle strobe: total is valid |
| total | output | COARSE_W+PRESC_W | Full-resolution pulse count |

## Verification
The hardest case to reach is an overflow that the last gated pulse produces in the cycle after stop. Here the settling cycle must class the edge as coarse, and recovery must then inject a full M pulses into an empty prescaler. The stimulus reaches this case by driving a burst whose length is a multiple of M, with the final external pulse placed in the same cycle as stopReq. Bursts with other residues, back-to-back pulses, a burst long enough to wrap the total, and start requests made mid-burst and in the done cycle cover the rest.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_DRAIN,
    ST_INJ,
    ST_DONE
  } state_t;

  typedef struct packed {
    logic clrCnt;
    logic incCoarse;
    logic incInj;
    logic latchTotal;
  } strobe_t;

endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    stopReq,
  input  logic    prescOvf,
  output strobe_t strobe,
  output logic    gateEn,
  output logic    injPulse,
  output logic    done
);

  state_t state, stateNxt;
  logic   ovfPrev;
  logic   phase, phaseNxt;
  logic   ovfEdge;

  assign ovfEdge = prescOvf & ~ovfPrev;

  always_comb begin
    stateNxt = state;
    phaseNxt = phase;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt      = ST_ACQ;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_ACQ: begin
        strobe.incCoarse = ovfEdge;
        if (stopReq) stateNxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        // gate already closed; an overflow from the final gated pulse lands here
        strobe.incCoarse = ovfEdge;
        stateNxt         = ST_INJ;
        phaseNxt         = 1'b1;
      end
      ST_INJ: begin
        strobe.incInj = phase;
        if (ovfEdge) begin
          strobe.latchTotal = 1'b1;
          stateNxt          = ST_DONE;
          phaseNxt          = 1'b0;
        end else begin
          phaseNxt = ~phase;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= 1'b0;
      ovfPrev <= 1'b0;
    end else begin
      state   <= stateNxt;
      phase   <= phaseNxt;
      ovfPrev <= prescOvf;
    end
  end

  assign gateEn   = (state == ST_ACQ);
  assign injPulse = (state == ST_INJ) && phase;
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/ppc_datapath.sv
module ppc_datapath
  import ppc_pkg::*;
#(
  parameter int PRESC_W  = 4,
  parameter int COARSE_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  output logic [COARSE_W+PRESC_W-1:0]  total
);

  localparam int INJ_W = PRESC_W + 1;
  localparam logic [INJ_W-1:0] MOD_V = INJ_W'(1) << PRESC_W;

  logic [COARSE_W-1:0] coarseCnt;
  logic [INJ_W-1:0]    injCnt;
  logic [PRESC_W-1:0]  remainder;

  // M - k, truncated: an empty prescaler (k == M) yields zero
  assign remainder = PRESC_W'(MOD_V - injCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseCnt <= '0;
      injCnt    <= '0;
      total     <= '0;
    end else begin
      if (strobe.clrCnt) begin
        coarseCnt <= '0;
        injCnt    <= '0;
      end else begin
        if (strobe.incCoarse) coarseCnt <= coarseCnt + 1'b1;
        if (strobe.incInj)    injCnt    <= injCnt + 1'b1;
      end
      if (strobe.latchTotal) total <= {coarseCnt, remainder};
    end
  end

endmodule

// File: rtl/prescaled_pulse_counter.sv
module prescaled_pulse_counter
  import ppc_pkg::*;
#(
  parameter int PRESC_W  = 4,
  parameter int COARSE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic                        stopReq,
  input  logic                        prescOvf,
  output logic                        gateEn,
  output logic                        injPulse,
  output logic                        done,
  output logic [COARSE_W+PRESC_W-1:0] total
);

  strobe_t strobe;

  ppc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .prescOvf (prescOvf),
    .strobe   (strobe),
    .gateEn   (gateEn),
    .injPulse (injPulse),
    .done     (done)
  );

  ppc_datapath #(
    .PRESC_W  (PRESC_W),
    .COARSE_W (COARSE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .total  (total)
  );

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int TOT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             stopReq,
  input logic             gateEn,
  input logic             injPulse,
  input logic             done,
  input logic [TOT_W-1:0] total
);

  AST_GATE_INJ_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(gateEn && injPulse)); // R5
  AST_INJ_SPACED:    assert property (@(posedge clk) disable iff (!rstN) injPulse |=> !injPulse); // R5
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_TOTAL_HELD:    assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(total)); // R7
  AST_GATE_NO_DONE:  assert property (@(posedge clk) disable iff (!rstN) gateEn |-> !done); // R2
  AST_GATE_OPEN:     assert property (@(posedge clk) disable iff (!rstN) $rose(gateEn) |-> $past(startReq)); // R2
  AST_GATE_CLOSE:    assert property (@(posedge clk) disable iff (!rstN) $fell(gateEn) |-> $past(stopReq)); // R2
  AST_DONE_NO_INJ:   assert property (@(posedge clk) disable iff (!rstN) done |-> !injPulse && !gateEn); // R5

endmodule

bind prescaled_pulse_counter ppc_checker #(.TOT_W(COARSE_W + PRESC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .stopReq  (stopReq),
  .gateEn   (gateEn),
  .injPulse (injPulse),
  .done     (done),
  .total    (total)
);

// File: tb/prescaled_pulse_counter_tb.sv
module prescaled_pulse_counter_tb;

  localparam int PW  = 4;
  localparam int CW  = 8;
  localparam int TW  = PW + CW;
  localparam int M   = 1 << PW;
  localparam int TOT_MOD = 1 << TW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic stopReq = 1'b0;
  logic extPulse = 1'b0;
  logic pOvf = 1'b0;
  logic gateEn, injPulse, done;
  logic [TW-1:0] total;

  int checks = 0;
  int errors = 0;

  // reference model state
  int  mMode = 0;      // 0 idle, 1 acquire, 2 settle, 3 recover, 4 done
  bit  mPhase = 0;
  bit  mOvfPrev = 0;
  int  mPassed = 0;
  int  mInjCount = 0;
  int  pCnt = 0;

  always #2.5 clk = ~clk;

  prescaled_pulse_counter #(.PRESC_W(PW), .COARSE_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .prescOvf(pOvf), .gateEn(gateEn), .injPulse(injPulse),
    .done(done), .total(total)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // external prescaler plus behavioural reference, one process
  always @(posedge clk) begin
    bit pulseIn;
    bit edgeSeen;
    if (!rstN) begin
      pOvf <= 1'b0; pCnt <= 0;
      mMode = 0; mPhase = 0; mOvfPrev = 0; mPassed = 0; mInjCount = 0;
    end else begin
      pulseIn = (extPulse && gateEn) || injPulse;
      pOvf <= pulseIn && (pCnt == M - 1);
      if (pulseIn) pCnt <= (pCnt + 1) % M;
      edgeSeen = pOvf && !mOvfPrev;
      mOvfPrev = pOvf;
      case (mMode)
        0: if (startReq) begin mMode = 1; mPassed = 0; mInjCount = 0; end
        1: begin
          if (extPulse) mPassed++;
          if (stopReq) mMode = 2;
        end
        2: begin mMode = 3; mPhase = 1; end
        3: begin
          if (mPhase) mInjCount++;
          if (edgeSeen) begin mMode = 4; mPhase = 0; end
          else mPhase = !mPhase;
        end
        default: mMode = 0;
      endcase
    end
  end

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(gateEn == (mMode == 1), "R2 gate", gateEn, mMode == 1);
      chk(injPulse == (mMode == 3 && mPhase), "R5 inject", injPulse, mMode == 3 && mPhase);
      chk(done == (mMode == 4), "R7 done", done, mMode == 4);
      if (mMode == 4)
        chk(total == TW'(mPassed % TOT_MOD), "R4 total", total, mPassed % TOT_MOD);
    end
  end

  task automatic measure(input int n, input int gap, input bit stopWithLast,
                         input bit startMid, input bit startAtDone, input string tag);
    int k;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      extPulse = 1'b1;
      if (stopWithLast && i == n - 1) stopReq = 1'b1;
      if (startMid && i == n / 2) startReq = 1'b1;   // R8 mid-burst request
      @(negedge clk);
      extPulse = 1'b0; stopReq = 1'b0; startReq = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    if (!stopWithLast || n == 0) begin
      stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    end
    k = 0;
    while (!done && k < 400) begin @(negedge clk); k++; end
    chk(done == 1'b1, {tag, " R7 done seen"}, done, 1);
    chk(total == TW'(n % TOT_MOD), {tag, " R4 total"}, total, n % TOT_MOD);
    chk(int'(total >> PW) == (n % TOT_MOD) / M, {tag, " R3 coarse"}, total >> PW, (n % TOT_MOD) / M);
    if (n % M == 0) begin
      chk(mInjCount == M, {tag, " R10 injected"}, mInjCount, M);
      chk(int'(total[PW-1:0]) == 0, {tag, " R10 remainder"}, total[PW-1:0], 0);
    end else begin
      chk(mInjCount == M - (n % M), {tag, " R5 injected"}, mInjCount, M - (n % M));
    end
    if (startAtDone) startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    chk(gateEn == 1'b0, {tag, " R8 start at done refused"}, gateEn, 0);
    chk(total == TW'(n % TOT_MOD), {tag, " R7 total held"}, total, n % TOT_MOD);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gateEn == 0 && injPulse == 0 && done == 0, "R1 outputs in reset", {gateEn, injPulse, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(gateEn == 0 && injPulse == 0 && done == 0, "R1 outputs after reset", {gateEn, injPulse, done}, 0);
    chk(total == 0, "R1 total after reset", total, 0);

    // R9: stop in idle does nothing
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(gateEn == 0 && injPulse == 0 && done == 0, "R9 stop in idle", {gateEn, injPulse, done}, 0);
      @(negedge clk);
    end

    measure(0,    1, 0, 0, 0, "empty");
    measure(5,    1, 0, 0, 0, "short");
    measure(16,   1, 1, 0, 0, "R6 last pulse at stop");
    measure(32,   0, 1, 0, 0, "R6 back-to-back multiple");
    measure(37,   2, 0, 0, 1, "residue5");
    measure(31,   0, 0, 1, 0, "R8 start mid-burst");
    measure(47,   0, 1, 0, 1, "R3 dense");
    measure(4099, 0, 0, 0, 0, "R4 wrap");
    measure(1,    3, 1, 0, 0, "single");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule